// File: doc/BRIEF.md
# Six-Pin Bus-Mapped Parallel I/O Port

This block gives software control of six general-purpose pins through a small byte-wide register bus. Three registers sit behind a two-bit address: a data latch, a direction register and a pullup-enable register. Software sets a pin's direction bit to turn its output driver on, and the driver then puts the latched data value on the pad. Reading the data register gives, for each bit, either the latched value or the synchronized pad level. The direction bit picks which one.

The port is asymmetric. Pin 5 can only be an input: its direction bit is not stored, always reads as zero, and its driver never turns on. Pin 4 can only be an output: its driver is always on, whatever its direction bit holds. That direction bit is still stored, and it still selects the read source for data bit 4. Pad inputs pass through a two-flop synchronizer before they reach the read path. Each pin's pullup request is suppressed while that pin's driver is on.

Top module: `gpio6_port`

## Requirements
- R1: After reset, the data, direction and pullup registers hold zero, `pad_out` and `pad_pu` are zero, and `pad_oe` is zero on every pin except pin 4.
- R2: A write with `addr`=0 latches `wdata[5:0]` into the data register whatever the directions are. `pad_out` shows the latched value from the cycle after the write.
- R3: A read with `addr`=0 returns, for each bit, the latched data when its direction bit is 1. When its direction bit is 0, it returns the pad level sampled two clocks earlier.
- R4: A write with `addr`=1 stores `wdata[4:0]` as direction bits. For pins 0 to 3, `pad_oe` equals the stored direction bit from the next cycle on.
- R5: Pin 5 is input-only. `pad_oe[5]` is always 0, direction bit 5 always reads 0, and data bit 5 always reads the synchronized pad level.
- R6: Pin 4 is output-only. `pad_oe[4]` is always 1. Direction bit 4 is stored and read back, and it selects the read source for data bit 4.
- R7: Bits 7:6 of every register read as 0 and ignore writes. Address 3 reads as 0, and writes to it change nothing.
- R8: A write with `addr`=2 stores `wdata[5:0]` as pullup enables. `pad_pu[i]` is the stored bit with pin i's output driver off.
- R9: `rdata` is combinational from `addr` while `rd_en` is 1, and it is zero while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select: 0 data, 1 direction, 2 pullup |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational |
| pin_in | input | 6 | Pad input levels |
| pad_oe | output | 6 | Per-pin output-driver enable |
| pad_out | output | 6 | Per-pin output value |
| pad_pu | output | 6 | Per-pin pullup enable |

## Verification
A register write takes effect at the clock edge on which the strobe is sampled. The pad controls and the read-back therefore change one cycle later, and the bench samples them on the following falling edge. A change on `pin_in` needs two rising edges to reach `rdata`, so input-path checks wait two full cycles after driving the pad. Reads are combinational, so the bench drives `addr` and `rd_en` on a falling edge and samples a moment later, before the next rising edge.

// File: rtl/gpio6_pkg.sv
package gpio6_pkg;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_PULL = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio6_sync.sv
module gpio6_sync #(
    parameter int unsigned NPINS  = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] async_in,
    output logic [NPINS-1:0] sync_out
);
    typedef logic [STAGES-1:0][NPINS-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio6_regs.sv
module gpio6_regs
    import gpio6_pkg::*;
#(
    parameter int unsigned NPINS    = 6,
    parameter logic [NPINS-1:0] DIR_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [NPINS-1:0] dat_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] pu_q
);
    typedef struct packed {
        logic [NPINS-1:0] dat;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] pu;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (sel)
                SEL_DATA: regs_d.dat = wdata[NPINS-1:0];
                SEL_DIR:  regs_d.dir = wdata[NPINS-1:0] & DIR_MASK;
                SEL_PULL: regs_d.pu  = wdata[NPINS-1:0];
                default:  regs_d     = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign dat_q = regs_q.dat;
    assign dir_q = regs_q.dir;
    assign pu_q  = regs_q.pu;
endmodule

// File: rtl/gpio6_pad_ctrl.sv
module gpio6_pad_ctrl #(
    parameter int unsigned NPINS    = 6,
    parameter int unsigned IN_ONLY  = 5,
    parameter int unsigned OUT_ONLY = 4
) (
    input  logic [NPINS-1:0] dat_q,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] pu_q,
    input  logic [NPINS-1:0] pin_sync,
    output logic [NPINS-1:0] oe,
    output logic [NPINS-1:0] out,
    output logic [NPINS-1:0] pu,
    output logic [NPINS-1:0] rd_val
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        if (i == IN_ONLY) begin : g_in
            assign oe[i] = 1'b0;
        end else if (i == OUT_ONLY) begin : g_out
            assign oe[i] = 1'b1;
        end else begin : g_bidir
            assign oe[i] = dir_q[i];
        end
        assign out[i]    = dat_q[i];
        assign pu[i]     = pu_q[i] & ~oe[i];
        assign rd_val[i] = dir_q[i] ? dat_q[i] : pin_sync[i];
    end
endmodule

// File: rtl/gpio6_port.sv
module gpio6_port
    import gpio6_pkg::*;
#(
    parameter int unsigned NPINS       = 6,
    parameter int unsigned IN_ONLY     = 5,
    parameter int unsigned OUT_ONLY    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [BUS_W-1:0]  rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_pu
);
    localparam logic [NPINS-1:0] DIR_MASK = ~(NPINS'(1) << IN_ONLY);

    reg_sel_e         sel;
    logic [NPINS-1:0] dat_q, dir_q, pu_q, pin_sync, rd_val;

    assign sel = reg_sel_e'(addr);

    gpio6_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    gpio6_regs #(.NPINS(NPINS), .DIR_MASK(DIR_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
        .dat_q(dat_q), .dir_q(dir_q), .pu_q(pu_q)
    );

    gpio6_pad_ctrl #(.NPINS(NPINS), .IN_ONLY(IN_ONLY), .OUT_ONLY(OUT_ONLY)) u_pad (
        .dat_q(dat_q), .dir_q(dir_q), .pu_q(pu_q), .pin_sync(pin_sync),
        .oe(pad_oe), .out(pad_out), .pu(pad_pu), .rd_val(rd_val)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_DATA: rdata = BUS_W'(rd_val);
                SEL_DIR:  rdata = BUS_W'(dir_q);
                SEL_PULL: rdata = BUS_W'(pu_q);
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio6_port_chk.sv
module gpio6_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rdata,
    input logic [5:0] pad_oe,
    input logic [5:0] pad_out,
    input logic [5:0] pad_pu
);
    a_r2_data_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> pad_out == $past(wdata[5:0]));
    a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 2'd0) |=> $stable(pad_out));
    a_r5_in_only_off: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[5] == 1'b0);
    a_r6_out_only_on: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[4] == 1'b1);
    a_r8_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == 6'd0);
    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[7:6] == 2'b00);
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == 8'd0);
    a_r4_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> pad_oe[3:0] == $past(wdata[3:0]));
endmodule

bind gpio6_port gpio6_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pu(pad_pu)
);

// File: tb/gpio6_port_bench.sv
module gpio6_port_bench;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic [5:0] pin_in = '0;
    logic [5:0] pad_oe, pad_out, pad_pu;

    int checks = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio6_port u_gpio6_port (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pad_oe(pad_oe),
        .pad_out(pad_out), .pad_pu(pad_pu)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata;
        rd_en = 1'b0;
        #1;
    endtask

    task automatic set_pins(logic [5:0] p);
        @(negedge clk);
        pin_in = p;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd0, d); check("R1 data", d, 8'h00);
        rd(2'd1, d); check("R1 dir", d, 8'h00);
        rd(2'd2, d); check("R1 pull", d, 8'h00);
        check("R1 oe", {2'b0, pad_oe}, 8'h10);
        check("R1 out", {2'b0, pad_out}, 8'h00);
        check("R1 pu", {2'b0, pad_pu}, 8'h00);
    endtask

    task automatic t_latch_and_drive();
        logic [7:0] d;
        wr(2'd0, 8'h2A);
        check("R2 out after write as inputs", {2'b0, pad_out}, 8'h2A);
        wr(2'd1, 8'h0F);
        check("R4 oe follows dir", {2'b0, pad_oe}, 8'h1F);
        rd(2'd1, d); check("R4 dir readback", d, 8'h0F);
        wr(2'd0, 8'h15);
        check("R2 out new value", {2'b0, pad_out}, 8'h15);
    endtask

    task automatic t_read_mux();
        logic [7:0] d;
        logic [5:0] dir;
        logic [5:0] dat;
        dir = 6'h0F; dat = 6'h15;
        set_pins(6'h3A);
        rd(2'd0, d);
        check("R3 mixed read", d, {2'b0, (dir & dat) | (~dir & 6'h3A)});
        @(negedge clk);
        pin_in = 6'h05;
        @(negedge clk);
        rd(2'd0, d);
        check("R3 one clock not yet visible", d, {2'b0, (dir & dat) | (~dir & 6'h3A)});
        @(negedge clk);
        rd(2'd0, d);
        check("R3 two clocks visible", d, {2'b0, (dir & dat) | (~dir & 6'h05)});
    endtask

    task automatic t_pin5();
        logic [7:0] d;
        wr(2'd1, 8'h3F);
        rd(2'd1, d); check("R5 dir bit5 reads zero", d, 8'h1F);
        check("R5 oe5 off", {7'b0, pad_oe[5]}, 8'h00);
        wr(2'd0, 8'h00);
        set_pins(6'h20);
        rd(2'd0, d); check("R5 data bit5 is pin", d, 8'h20);
    endtask

    task automatic t_pin4();
        logic [7:0] d;
        wr(2'd1, 8'h00);
        check("R6 oe4 on with dir clear", {2'b0, pad_oe}, 8'h10);
        wr(2'd0, 8'h10);
        set_pins(6'h00);
        rd(2'd0, d); check("R6 dir4=0 reads pin", d, 8'h00);
        wr(2'd1, 8'h10);
        rd(2'd1, d); check("R6 dir4 stored", d, 8'h10);
        rd(2'd0, d); check("R6 dir4=1 reads latch", d, 8'h10);
    endtask

    task automatic t_upper_and_hole();
        logic [7:0] d;
        wr(2'd1, 8'h3F);
        wr(2'd0, 8'hC0);
        rd(2'd0, d); check("R7 data upper ignored", d, 8'h00);
        wr(2'd2, 8'hC3);
        rd(2'd2, d); check("R7 pull upper ignored", d, 8'h03);
        wr(2'd3, 8'hFF);
        rd(2'd3, d); check("R7 addr3 reads zero", d, 8'h00);
        rd(2'd0, d); check("R7 addr3 no data change", d, 8'h00);
        rd(2'd1, d); check("R7 addr3 no dir change", d, 8'h1F);
        rd(2'd2, d); check("R7 addr3 no pull change", d, 8'h03);
    endtask

    task automatic t_pullup();
        logic [7:0] d;
        wr(2'd1, 8'h05);
        wr(2'd2, 8'h3F);
        rd(2'd2, d); check("R8 pull readback", d, 8'h3F);
        check("R8 pu masked by oe", {2'b0, pad_pu}, 8'h2A);
        wr(2'd1, 8'h00);
        check("R8 pu after dir clear", {2'b0, pad_pu}, 8'h2F);
    endtask

    task automatic t_rd_strobe();
        addr = 2'd2; rd_en = 1'b0;
        #1 check("R9 idle rdata zero", rdata, 8'h00);
        rd_en = 1'b1;
        #1 check("R9 strobe shows reg", rdata, 8'h3F);
        addr = 2'd1;
        #1 check("R9 follows addr", rdata, 8'h00);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_and_drive();
        t_read_mux();
        t_pin5();
        t_pin4();
        t_upper_and_hole();
        t_pullup();
        t_rd_strobe();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule